// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one read or write burst for a double-data-rate memory device whose core fetches two data words per clock. A start pulse captures a starting column and the burst settings decoded from the low field bits of the mode register word. From the next cycle the block presents two column addresses per clock, a lead column for the first beat of the pair and a trail column for the second, until the burst is complete.

Addresses walk only through the low bits inside the aligned block picked by the burst length (2, 4 or 8 columns) and wrap at that block's edge. Two orderings are offered: a wrapping add and an XOR walk. A reserved burst-length or latency code raises an error flag, and a start issued under such a code is dropped. A stop input cuts a running burst short, and a fresh start during a burst restarts it with the new column and settings.

Top module: `burst_col_gen`

## Requirements
- R1: Mode bits [2:0] select the burst length: 001 gives 2 beats, 010 gives 4, 011 gives 8, and an accepted burst occupies exactly length/2 valid cycles.
- R2: Mode bit 3 selects the order: 0 is the wrapping-add order, 1 is the XOR order.
- R3: Mode bits [6:4] select the read latency: 011 drives `cas_lat` to 3, 100 drives it to 4; any other value drives it to 0.
- R4: `mode_err` is high, in the same cycle, whenever bits [2:0] or bits [6:4] hold a reserved code; a start pulse seen with `mode_err` high starts nothing and leaves a running burst untouched.
- R5: In wrapping-add order, beat i carries low bits (s + i) mod L, where s is the start column's low bits and L the burst length (start 5, length 8 gives 5,6,7,0,1,2,3,4).
- R6: In XOR order, beat i carries low bits s XOR i (start 5, length 8 gives 5,4,7,6,1,0,3,2).
- R7: Column bits at and above bit log2(L) equal those of the start column for every beat of the burst.
- R8: A start sampled at a clock edge gives `beat_valid` high from that edge on, with beat 2k on `col_lead` and beat 2k+1 on `col_trail` in the k-th valid cycle.
- R9: `beat_last` is high only in the final valid cycle of a burst and never while `beat_valid` is low.
- R10: `stop` sampled high during a valid cycle ends the burst after that cycle; `stop` while idle has no effect; `start` wins over `stop` in the same cycle.
- R11: An accepted start during a burst, including in its last cycle, restarts at beat 0 of the new column with the new settings on the next cycle.
- R12: After reset, `beat_valid` and `beat_last` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bits | input | 7 | Burst length, order and latency field bits of the mode register word |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Starting column address |
| stop | input | 1 | End the running burst after the current cycle |
| col_lead | output | 9 | Column of the first beat of the current pair |
| col_trail | output | 9 | Column of the second beat of the current pair |
| beat_valid | output | 1 | Column pair is valid this cycle |
| beat_last | output | 1 | Final pair of the burst |
| mode_err | output | 1 | Reserved code present in `mode_bits` |
| cas_lat | output | 3 | Decoded read latency (3 or 4, 0 when reserved) |

## Verification
The functions that meet in one cycle are burst termination and burst launch: a stop, a restart, and the natural last beat can coincide with a new start. The bench provokes this by raising stop and start together mid-burst, by starting again exactly in the last cycle of a burst, and by issuing a start under a reserved code while a burst runs. Each case is judged by a scoreboard that trims the expected pairs of the cut burst at the cycle the rule names and then expects the new burst's pairs, or the old burst's remaining pairs, with no gap and no extra beat.

// File: rtl/colgen_pkg.sv
// Shared field positions and decoded-settings type for the burst column
// address generator. Assumes the mode field layout: length in [2:0],
// order in [3], read latency in [6:4].
package colgen_pkg;
    localparam int MODE_W     = 7;
    localparam int LEN_LSB    = 0;
    localparam int LEN_W      = 3;
    localparam int ORDER_BIT  = 3;
    localparam int LAT_LSB    = 4;
    localparam int LAT_W      = 3;
    localparam int MAX_LOG    = 3;          // log2 of the longest burst
    localparam int PAIR_W     = MAX_LOG - 1; // index of a pair within a burst

    typedef struct packed {
        logic [1:0] len_log;    // log2 of burst length (1..3)
        logic       xor_order;  // 1: XOR walk, 0: wrapping add
        logic [2:0] lat;        // decoded latency, 0 if reserved
        logic       bad_len;
        logic       bad_lat;
    } mode_fields_t;
endpackage

// File: rtl/colgen_mode_decode.sv
// Decodes the mode field bits into burst length, order and latency and
// flags reserved codes. Purely combinational; assumes the caller holds
// the field stable while a start is presented.
module colgen_mode_decode
    import colgen_pkg::*;
(
    input  logic [MODE_W-1:0] mode_bits,
    output mode_fields_t      fields
);
    logic [LEN_W-1:0] len_code;
    logic [LAT_W-1:0] lat_code;

    assign len_code = mode_bits[LEN_LSB +: LEN_W];
    assign lat_code = mode_bits[LAT_LSB +: LAT_W];

    // Map each field code to its setting, marking reserved values.
    always_comb begin
        fields           = '0;
        fields.xor_order = mode_bits[ORDER_BIT];
        case (len_code)
            3'b001:  fields.len_log = 2'd1;
            3'b010:  fields.len_log = 2'd2;
            3'b011:  fields.len_log = 2'd3;
            default: begin
                fields.len_log = 2'd1;
                fields.bad_len = 1'b1;
            end
        endcase
        case (lat_code)
            3'b011:  fields.lat = 3'd3;
            3'b100:  fields.lat = 3'd4;
            default: begin
                fields.lat     = 3'd0;
                fields.bad_lat = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/colgen_beat_ctrl.sv
// Tracks which column pair of a burst is on the outputs. Assumes go is
// only raised for an accepted start; go has priority over stop and over
// the natural end of a burst.
module colgen_beat_ctrl
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop,
    input  logic [1:0]        len_log,
    output logic              busy,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              last
);
    logic [PAIR_W-1:0] last_idx;

    // Index of the final pair for the captured length.
    always_comb begin
        case (len_log)
            2'd1:    last_idx = PAIR_W'(0);
            2'd2:    last_idx = PAIR_W'(1);
            default: last_idx = PAIR_W'(3);
        endcase
    end

    assign last = busy && (pair_idx == last_idx);

    // Launch, advance and end the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pair_idx <= '0;
        end else if (go) begin
            busy     <= 1'b1;
            pair_idx <= '0;
        end else if (busy && (stop || last)) begin
            busy     <= 1'b0;
            pair_idx <= '0;
        end else if (busy) begin
            pair_idx <= pair_idx + PAIR_W'(1);
        end
    end

    // R10: a stop in a valid cycle without a new start ends the burst.
    a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        busy && stop && !go |=> !busy);
    // R9: after the final pair the burst is over unless restarted.
    a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        last && !go |=> !busy);
    // R11: an accepted start always lands on pair 0 next cycle.
    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy && pair_idx == '0);
endmodule

// File: rtl/colgen_addr_calc.sv
// Forms the lead and trail columns of the current pair from the captured
// start column. Assumes COL_W >= 3 so the largest block fits in the column.
module colgen_addr_calc
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [1:0]        len_log,
    input  logic              xor_order,
    input  logic [PAIR_W-1:0] pair_idx,
    output logic [COL_W-1:0]  col_lead,
    output logic [COL_W-1:0]  col_trail
);
    localparam int HI_W = COL_W - MAX_LOG;

    logic [MAX_LOG-1:0] low_mask;
    logic [COL_W-1:0]   blk_mask;
    logic [COL_W-1:0]   lane_col [2];

    // Low-bit mask of the aligned block for the captured length.
    always_comb begin
        case (len_log)
            2'd1:    low_mask = 3'b001;
            2'd2:    low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
    end

    assign blk_mask = {{HI_W{1'b0}}, low_mask};

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [MAX_LOG-1:0] beat;
        logic [MAX_LOG-1:0] walk;
        assign beat = {pair_idx, 1'(ln)};
        // Walk the low bits by add or XOR, then keep the block's upper bits.
        always_comb begin
            walk = xor_order ? (base_col[MAX_LOG-1:0] ^ beat)
                             : (base_col[MAX_LOG-1:0] + beat);
            lane_col[ln] = (base_col & ~blk_mask) |
                           ({{HI_W{1'b0}}, walk} & blk_mask);
        end
    end

    assign col_lead  = lane_col[0];
    assign col_trail = lane_col[1];
endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column address generator: decodes the mode field,
// captures start column and settings on an accepted start, and presents
// one column pair per clock. Assumes synchronous active-low reset.
module burst_col_gen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_lead,
    output logic [COL_W-1:0]  col_trail,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              mode_err,
    output logic [2:0]        cas_lat
);
    mode_fields_t      fields;
    logic              go;
    logic [COL_W-1:0]  base_q;
    logic [1:0]        len_q;
    logic              xor_q;
    logic [PAIR_W-1:0] pair_idx;

    colgen_mode_decode u_dec (
        .mode_bits (mode_bits),
        .fields    (fields)
    );

    assign mode_err = fields.bad_len | fields.bad_lat;
    assign cas_lat  = fields.lat;
    assign go       = start && !mode_err;

    // Hold the start column and settings of the burst in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= 2'd1;
            xor_q  <= 1'b0;
        end else if (go) begin
            base_q <= start_col;
            len_q  <= fields.len_log;
            xor_q  <= fields.xor_order;
        end
    end

    colgen_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .stop     (stop),
        .len_log  (len_q),
        .busy     (beat_valid),
        .pair_idx (pair_idx),
        .last     (beat_last)
    );

    colgen_addr_calc #(.COL_W(COL_W)) u_addr (
        .base_col  (base_q),
        .len_log   (len_q),
        .xor_order (xor_q),
        .pair_idx  (pair_idx),
        .col_lead  (col_lead),
        .col_trail (col_trail)
    );

    // R8: an accepted start yields a valid pair on the next cycle.
    a_r8_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mode_err |=> beat_valid);
    // R4: a start under a reserved code from idle starts nothing.
    a_r4_err_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        start && mode_err && !beat_valid |=> !beat_valid);
    // R7: block bits stay put from one pair to the next within a burst.
    a_r7_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !start |=> !beat_valid ||
        col_lead[COL_W-1:MAX_LOG] == $past(col_lead[COL_W-1:MAX_LOG]));
    // R5/R6: the two beats of one pair never name the same column.
    a_r6_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> col_lead != col_trail);
    // R9: the last flag never stands without a valid pair.
    a_r9_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);
endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
    localparam int COL_W = 9;

    typedef struct {
        logic [COL_W-1:0] lead;
        logic [COL_W-1:0] trail;
        logic             last;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [6:0]       mode_bits = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_lead, col_trail;
    logic             beat_valid, beat_last, mode_err;
    logic [2:0]       cas_lat;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .start(start),
        .start_col(start_col), .stop(stop), .col_lead(col_lead),
        .col_trail(col_trail), .beat_valid(beat_valid), .beat_last(beat_last),
        .mode_err(mode_err), .cas_lat(cas_lat)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Mode field: length code [2:0], order [3], latency code [6:4].
    function automatic logic [6:0] mk(logic [2:0] len, logic ord, logic [2:0] lat);
        return {lat, ord, len};
    endfunction

    function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int i, int bl, logic ord);
        int low;
        low = ord ? ((s % bl) ^ i) : ((s + i) % bl);
        return COL_W'((s / bl) * bl + low);
    endfunction

    // Driver: called just after a rising edge; keeps the pair on show, then
    // queues the pairs of the new burst.
    task automatic launch(logic [6:0] m, logic [COL_W-1:0] c, string tag);
        int bl;
        bl = 1 << int'(m[2:0]);
        while (q.size() > 1) void'(q.pop_back());
        if (!beat_valid) q.delete();
        for (int k = 0; k < bl / 2; k++) begin
            exp_t e;
            e.lead  = exp_col(c, 2 * k, bl, m[3]);
            e.trail = exp_col(c, 2 * k + 1, bl, m[3]);
            e.last  = (k == bl / 2 - 1);
            e.tag   = tag;
            q.push_back(e);
        end
        mode_bits = m; start_col = c; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic bad_launch(logic [6:0] m, logic [COL_W-1:0] c);
        mode_bits = m; start_col = c; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic drain(string tag);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk({tag, " pairs outstanding"}, q.size(), 0);
        chk({tag, " idle after burst"}, int'(beat_valid), 0);
        @(posedge clk); #1;
    endtask

    // Monitor: pops and compares one expected pair per valid cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (beat_valid) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8 unexpected pair: actual %0d/%0d expected none",
                             col_lead, col_trail);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    n_chk++;
                    if (col_lead !== e.lead || col_trail !== e.trail || beat_last !== e.last) begin
                        n_bad++;
                        $display("FAIL %s: actual %0d/%0d last %0b expected %0d/%0d last %0b",
                                 e.tag, col_lead, col_trail, beat_last, e.lead, e.trail, e.last);
                    end
                end
            end else if (beat_last) begin
                n_chk++; n_bad++;
                $display("FAIL R9 last without valid: actual 1 expected 0");
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R12 valid in reset", int'(beat_valid), 0);
        chk("R12 last in reset", int'(beat_last), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12 valid after reset", int'(beat_valid), 0);
        @(posedge clk); #1;

        // R3 / R4: decode and reserved flags.
        mode_bits = mk(3'b011, 1'b0, 3'b011); #1;
        chk("R3 latency 3", int'(cas_lat), 3);
        chk("R4 legal codes", int'(mode_err), 0);
        mode_bits = mk(3'b010, 1'b1, 3'b100); #1;
        chk("R3 latency 4", int'(cas_lat), 4);
        mode_bits = mk(3'b011, 1'b0, 3'b101); #1;
        chk("R3 reserved latency", int'(cas_lat), 0);
        chk("R4 reserved latency flag", int'(mode_err), 1);
        mode_bits = mk(3'b000, 1'b0, 3'b011); #1;
        chk("R4 length code 000", int'(mode_err), 1);
        mode_bits = mk(3'b100, 1'b0, 3'b011); #1;
        chk("R4 length code 100", int'(mode_err), 1);
        mode_bits = mk(3'b111, 1'b1, 3'b100); #1;
        chk("R4 length code 111", int'(mode_err), 1);
        @(posedge clk); #1;

        // R1 / R5 / R7: wrapping add, each length.
        launch(mk(3'b011, 1'b0, 3'b011), 9'h1A5, "R5 add len8 start 5");
        drain("R5");
        launch(mk(3'b010, 1'b0, 3'b011), 9'h1A6, "R1 add len4");
        drain("R1");
        launch(mk(3'b001, 1'b0, 3'b100), 9'h0FF, "R7 add len2 top of block");
        drain("R7");
        // R2 / R6: XOR order.
        launch(mk(3'b011, 1'b1, 3'b011), 9'h045, "R6 xor len8 start 5");
        drain("R6");
        launch(mk(3'b010, 1'b1, 3'b100), 9'h103, "R2 xor len4 start 3");
        drain("R2");
        launch(mk(3'b001, 1'b1, 3'b011), 9'h0FF, "R6 xor len2");
        drain("R6 len2");

        // R4: reserved start from idle and during a burst.
        bad_launch(mk(3'b101, 1'b0, 3'b011), 9'h010);
        drain("R4 idle");
        launch(mk(3'b011, 1'b0, 3'b011), 9'h0F2, "R4 burst kept");
        bad_launch(mk(3'b011, 1'b0, 3'b111), 9'h001);
        drain("R4 busy");

        // R10: stop while idle, mid-burst, and together with a start.
        stop = 1'b1; @(posedge clk); #1 stop = 1'b0;
        @(negedge clk);
        chk("R10 stop idle", int'(beat_valid), 0);
        @(posedge clk); #1;
        launch(mk(3'b011, 1'b1, 3'b011), 9'h133, "R10 stopped burst");
        @(posedge clk); #1;
        while (q.size() > 1) void'(q.pop_back());
        stop = 1'b1; @(posedge clk); #1 stop = 1'b0;
        drain("R10 stop");
        launch(mk(3'b011, 1'b0, 3'b011), 9'h007, "R10 before tie");
        stop = 1'b1;
        launch(mk(3'b010, 1'b1, 3'b100), 9'h0A1, "R10 start beats stop");
        stop = 1'b0;
        drain("R10 tie");

        // R11: restart mid-burst and on the last cycle.
        launch(mk(3'b011, 1'b0, 3'b011), 9'h18C, "R11 first burst");
        launch(mk(3'b011, 1'b1, 3'b100), 9'h06E, "R11 mid restart");
        repeat (3) @(posedge clk);
        #1;
        launch(mk(3'b001, 1'b0, 3'b011), 9'h154, "R11 restart on last");
        drain("R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule